// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This unit owns the program counter of a 32-bit RISC core with fixed 4-byte instructions and delayed control transfer. On each cycle in which an instruction issues, the decoder gives it the control-flow class of the instruction at the current PC, the two source register values, the 16-bit branch displacement and the 26-bit jump field. The unit resolves the condition straight from the register values, because the core has no flag register. It then works out the redirect address and drives the link write for call instructions.

Transfers are delayed by one instruction. The instruction that follows a branch or jump always issues. A taken transfer is held in a pending redirect register and is loaded into the PC one issue later, after the delay-slot instruction has gone out at PC+4. The core runs the unit with a single advance enable. When that enable is low, both the PC and the pending redirect keep their values.

Top module: `npc_unit`

## Requirements
- R1: While rst_n is low, the PC resets to RESET_PC (default 32'h0040_0000) and no redirect is pending.
- R2: When an instruction with class NONE (code 0) issues and no redirect is pending, the PC advances by 4. While adv is low, the PC and the pending redirect do not change.
- R3: Class EQ (code 1) is taken when rs_val equals rt_val. Class NE (code 2) is taken when they differ.
- R4: rs_val is compared as a signed number against zero by four classes: LEZ (code 3) is taken for rs <= 0, GTZ (code 4) for rs > 0, LTZ (code 5) for rs < 0 and GEZ (code 6) for rs >= 0.
- R5: The target of a conditional branch is (PC+4) plus the sign-extended 16-bit displacement multiplied by 4.
- R6: Classes JMP (code 7) and CALL (code 8) go to the top 4 bits of PC+4 followed by the 26-bit jump field and two zero bits.
- R7: Class JREG (code 9) goes to the address held in rs_val.
- R8: After a taken transfer at address A, the next issued PC is A+4 (the delay slot), and the PC after that is the target. After a branch that is not taken, the PC goes to A+4 and then A+8.
- R9: link_we_o is 1 only while a CALL issues, and link_val_o is then the address of the CALL plus 4. For every other class, link_we_o is 0.
- R10: taken_o gives the resolved condition of the current instruction. It is always 1 for JMP, CALL and JREG, and it is 0 for NONE and for codes 10 to 15.
- R11: When the delay slot itself holds a taken transfer, the first target issues next, and the slot's own target issues after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv | input | 1 | An instruction issues this cycle |
| cf_kind | input | 4 | Control-flow class of the instruction at pc_o |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| br_off | input | 16 | Branch displacement in words |
| j_field | input | 26 | Jump target field |
| pc_o | output | 32 | Address of the instruction issuing now |
| pc_next_o | output | 32 | PC that the next advance will load |
| taken_o | output | 1 | Transfer taken by the current instruction |
| link_val_o | output | 32 | Return address written to register 31 |
| link_we_o | output | 1 | Write enable for the return-address register |

## Verification
The hardest case to reach is a redirect that is pending while the delay-slot instruction is itself a taken transfer. In that case the pending target has to issue before the slot's own target. The bench reaches this case by issuing a taken branch and then putting a JMP in the slot. It also issues a branch with displacement zero, whose target is its own delay slot, so that address issues twice in a row. Taken and not-taken outcomes are driven for every class, with operands placed on the zero boundary and on the sign boundary.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [3:0] {
    CF_NONE = 4'd0,
    CF_EQ   = 4'd1,
    CF_NE   = 4'd2,
    CF_LEZ  = 4'd3,
    CF_GTZ  = 4'd4,
    CF_LTZ  = 4'd5,
    CF_GEZ  = 4'd6,
    CF_JMP  = 4'd7,
    CF_CALL = 4'd8,
    CF_JREG = 4'd9
  } cf_kind_e;

  function automatic logic is_cond_branch(input logic [3:0] k);
    return (k >= 4'd1) && (k <= 4'd6);
  endfunction

  function automatic logic is_region_jump(input logic [3:0] k);
    return (k == 4'd7) || (k == 4'd8);
  endfunction

endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [3:0]      kind,
  input  logic [XLEN-1:0] rs,
  input  logic [XLEN-1:0] rt,
  output logic            take
);

  logic eq_w;
  logic neg_w;
  logic zero_w;

  always_comb begin
    eq_w   = (rs == rt);
    neg_w  = rs[XLEN-1];
    zero_w = (rs == '0);
  end

  always_comb begin
    unique case (kind)
      CF_EQ:   take = eq_w;
      CF_NE:   take = !eq_w;
      CF_LEZ:  take = neg_w || zero_w;
      CF_GTZ:  take = !neg_w && !zero_w;
      CF_LTZ:  take = neg_w;
      CF_GEZ:  take = !neg_w;
      CF_JMP, CF_CALL, CF_JREG: take = 1'b1;
      default: take = 1'b0;
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int JT_W  = 26
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [3:0]       kind,
  input  logic [XLEN-1:0]  rs,
  input  logic [OFF_W-1:0] off,
  input  logic [JT_W-1:0]  jf,
  output logic [XLEN-1:0]  tgt,
  output logic [XLEN-1:0]  link,
  output logic             link_en
);

  localparam int EXT_W = XLEN - OFF_W - 2;
  localparam int REG_W = XLEN - JT_W - 2;

  logic [XLEN-1:0] slot_pc;
  logic [XLEN-1:0] rel_tgt;
  logic [XLEN-1:0] abs_tgt;

  always_comb begin
    slot_pc = pc + XLEN'(4);
    rel_tgt = slot_pc + {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
    abs_tgt = {slot_pc[XLEN-1 -: REG_W], jf, 2'b00};
  end

  always_comb begin
    if (is_region_jump(kind))      tgt = abs_tgt;
    else if (kind == CF_JREG)      tgt = rs;
    else                           tgt = rel_tgt;
    link    = slot_pc;
    link_en = (kind == CF_CALL);
  end

endmodule

// File: rtl/npc_seq.sv
module npc_seq #(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            take,
  input  logic [XLEN-1:0] tgt,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] pc_nxt
);

  logic            pend_v_q, pend_v_d;
  logic [XLEN-1:0] pend_t_q, pend_t_d;
  logic [XLEN-1:0] pc_d;

  always_comb begin
    pc_nxt   = pend_v_q ? pend_t_q : (pc_q + XLEN'(4));
    pc_d     = pc_q;
    pend_v_d = pend_v_q;
    pend_t_d = pend_t_q;
    if (adv) begin
      pc_d     = pc_nxt;
      pend_v_d = take;
      if (take) pend_t_d = tgt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= RESET_PC;
      pend_v_q <= 1'b0;
      pend_t_q <= '0;
    end else begin
      pc_q     <= pc_d;
      pend_v_q <= pend_v_d;
      pend_t_q <= pend_t_d;
    end
  end

  // R2
  hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(pc_q) && $stable(pend_v_q));

  // R8
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !pend_v_q |=> pc_q == $past(pc_q) + XLEN'(4));

  // R11
  slot_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && pend_v_q && take |=> pend_v_q);

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          OFF_W    = 16,
  parameter int          JT_W     = 26,
  parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [3:0]       cf_kind,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  input  logic [OFF_W-1:0] br_off,
  input  logic [JT_W-1:0]  j_field,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  pc_next_o,
  output logic             taken_o,
  output logic [XLEN-1:0]  link_val_o,
  output logic             link_we_o
);

  logic            take_w;
  logic [XLEN-1:0] tgt_w;
  logic [XLEN-1:0] link_w;
  logic            link_en_w;

  npc_cond #(.XLEN(XLEN)) u_cond (
    .kind (cf_kind),
    .rs   (rs_val),
    .rt   (rt_val),
    .take (take_w)
  );

  npc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .JT_W(JT_W)) u_tgt (
    .pc      (pc_o),
    .kind    (cf_kind),
    .rs      (rs_val),
    .off     (br_off),
    .jf      (j_field),
    .tgt     (tgt_w),
    .link    (link_w),
    .link_en (link_en_w)
  );

  npc_seq #(.XLEN(XLEN), .RESET_PC(XLEN'(RESET_PC))) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (adv),
    .take   (take_w),
    .tgt    (tgt_w),
    .pc_q   (pc_o),
    .pc_nxt (pc_next_o)
  );

  always_comb begin
    taken_o    = take_w;
    link_val_o = link_w;
    link_we_o  = link_en_w;
  end

  // R9
  link_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> taken_o && (link_val_o == pc_o + XLEN'(4)));

  // R10
  jump_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_kind == CF_JMP || cf_kind == CF_JREG) |-> taken_o && !link_we_o);

endmodule

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;

  logic        clk;
  logic        rst_n;
  logic        adv;
  logic [3:0]  cf_kind;
  logic [31:0] rs_val, rt_val;
  logic [15:0] br_off;
  logic [25:0] j_field;
  logic [31:0] pc_o, pc_next_o, link_val_o;
  logic        taken_o, link_we_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  npc_unit u0 (
    .clk(clk), .rst_n(rst_n), .adv(adv), .cf_kind(cf_kind),
    .rs_val(rs_val), .rt_val(rt_val), .br_off(br_off), .j_field(j_field),
    .pc_o(pc_o), .pc_next_o(pc_next_o), .taken_o(taken_o),
    .link_val_o(link_val_o), .link_we_o(link_we_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] k, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] o, input logic [25:0] j);
    adv = 1'b1; cf_kind = k; rs_val = a; rt_val = b; br_off = o; j_field = j;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    adv = 1'b0; cf_kind = 4'd0;
  endtask

  task automatic t_reset();
    chk("R1 reset pc", pc_o, 32'h0040_0000);
    chk("R1 no pending", pc_next_o, 32'h0040_0004);
  endtask

  task automatic t_seq();
    logic [31:0] a;
    a = pc_o;
    for (int i = 1; i <= 3; i++) begin
      drive(4'd0, 0, 0, 0, 0);
      chk("R10 none not taken", {31'd0, taken_o}, 0);
      tick();
      chk("R2 sequential", pc_o, a + 32'(4 * i));
    end
    repeat (2) tick();
    chk("R2 hold when idle", pc_o, a + 12);
    drive(4'd12, 32'h5, 32'h5, 16'h4, 0);
    chk("R10 unused code", {31'd0, taken_o}, 0);
    tick();
  endtask

  task automatic t_branch(input string req, input logic [3:0] k, input logic [31:0] a,
                          input logic [31:0] b, input logic exp_t, input logic [15:0] o);
    logic [31:0] base, tg;
    base = pc_o;
    tg = base + 4 + {{14{o[15]}}, o, 2'b00};
    drive(k, a, b, o, 26'h0);
    chk({req, " taken"}, {31'd0, taken_o}, {31'd0, exp_t});
    chk("R9 no link on branch", {31'd0, link_we_o}, 0);
    tick();
    chk("R8 delay slot", pc_o, base + 4);
    drive(4'd0, 0, 0, 0, 0);
    tick();
    chk({req, " R5 R8 after slot"}, pc_o, exp_t ? tg : base + 8);
  endtask

  task automatic t_jumps();
    logic [31:0] base;
    base = pc_o;
    drive(4'd8, 0, 0, 0, 26'h012_3456);
    chk("R9 call link_we", {31'd0, link_we_o}, 1);
    chk("R9 call link_val", link_val_o, base + 4);
    chk("R10 call taken", {31'd0, taken_o}, 1);
    tick();
    drive(4'd0, 0, 0, 0, 0); tick();
    chk("R6 call target", pc_o, {base[31:28] , 26'h012_3456, 2'b00});
    base = pc_o;
    drive(4'd7, 0, 0, 0, 26'h3FF_FFFF);
    chk("R9 jmp no link", {31'd0, link_we_o}, 0);
    tick(); drive(4'd0, 0, 0, 0, 0); tick();
    chk("R6 jmp target", pc_o, {base[31:28], 26'h3FF_FFFF, 2'b00});
    drive(4'd9, 32'h0040_1230, 0, 0, 0);
    chk("R10 jreg taken", {31'd0, taken_o}, 1);
    tick(); drive(4'd0, 0, 0, 0, 0); tick();
    chk("R7 jreg target", pc_o, 32'h0040_1230);
  endtask

  task automatic t_slot_self();
    logic [31:0] base;
    base = pc_o;
    drive(4'd1, 7, 7, 16'h0000, 0); tick();
    chk("R8 slot at zero offset", pc_o, base + 4);
    drive(4'd0, 0, 0, 0, 0); tick();
    chk("R5 target equals slot", pc_o, base + 4);
    drive(4'd0, 0, 0, 0, 0); tick();
    chk("R2 resume after reissue", pc_o, base + 8);
  endtask

  task automatic t_slot_xfer();
    logic [31:0] base, t1, t2;
    base = pc_o;
    t1 = base + 4 + 32'h40;
    drive(4'd2, 1, 2, 16'h0010, 0); tick();
    chk("R11 slot issues", pc_o, base + 4);
    t2 = {pc_o[31:28] + 4'd0, 26'h000_2000, 2'b00};
    drive(4'd7, 0, 0, 0, 26'h000_2000); tick();
    chk("R11 first target", pc_o, t1);
    drive(4'd0, 0, 0, 0, 0); tick();
    chk("R11 slot target", pc_o, t2);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; adv = 1'b0; cf_kind = 0; rs_val = 0; rt_val = 0; br_off = 0; j_field = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seq();
    t_branch("R3 eq hit",   4'd1, 32'h1234, 32'h1234, 1, 16'h0005);
    t_branch("R3 eq miss",  4'd1, 32'h1234, 32'h1235, 0, 16'h0005);
    t_branch("R3 ne hit",   4'd2, 32'h0, 32'h8000_0000, 1, 16'h0005);
    t_branch("R3 ne miss",  4'd2, 32'hA, 32'hA, 0, 16'h0005);
    t_branch("R4 lez zero", 4'd3, 32'h0, 0, 1, 16'hFFFE);
    t_branch("R4 lez neg",  4'd3, 32'hFFFF_FFFF, 0, 1, 16'h0003);
    t_branch("R4 lez pos",  4'd3, 32'h1, 0, 0, 16'h0003);
    t_branch("R4 gtz pos",  4'd4, 32'h7FFF_FFFF, 0, 1, 16'h0008);
    t_branch("R4 gtz zero", 4'd4, 32'h0, 0, 0, 16'h0008);
    t_branch("R4 gtz neg",  4'd4, 32'h8000_0000, 0, 0, 16'h0008);
    t_branch("R4 ltz neg",  4'd5, 32'hFFFF_FFFB, 0, 1, 16'hFFF0);
    t_branch("R4 ltz zero", 4'd5, 32'h0, 0, 0, 16'hFFF0);
    t_branch("R4 gez zero", 4'd6, 32'h0, 0, 1, 16'h0002);
    t_branch("R4 gez neg",  4'd6, 32'hFFFF_FFFF, 0, 0, 16'h0002);
    t_jumps();
    t_slot_self();
    t_slot_xfer();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule